// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This block watches a parallel port of input pins and reports selected signal edges to a processor. Each pin is first brought into the local clock domain through a chain of flops. A per-pin mode then picks which edges count: none, low-to-high, high-to-low, or every transition. When a counted edge arrives, the pin's bit is latched in a sticky status register, and one shared interrupt line stays high for as long as any status bit is set.

Software talks to the block through a small register port with one address bit. Address 0 holds the mode word, which can be written and read back. Address 1 returns the status bits, and reading it clears exactly the bits that were returned. An edge that lands in the same clock as that read survives into the next status value. Detection compares each synchronized sample with the sample one clock earlier. It never compares with the level seen at the last read, so a short pulse between two reads is still recorded.

Top module: `piu_port_irq`

## Requirements
- R1: After reset the status is empty, `irq` and `rvalid` are low, and the mode word reads 0, so every pin is disabled.
- R2: Pin i takes its mode from bits [2i+1:2i] of the mode word. Code 00 disables the pin, and no edge on a disabled pin ever sets its status bit.
- R3: Code 01 (rising) sets the pin's status bit on a 0-to-1 transition and ignores 1-to-0 transitions.
- R4: Code 10 (falling) sets the pin's status bit on a 1-to-0 transition and ignores 0-to-1 transitions.
- R5: Code 11 (any) sets the status bit on every transition. This includes a pulse that starts and ends between two status reads.
- R6: `irq` is high exactly while at least one status bit is set, and it falls only as the result of a status read.
- R7: With `rd_en` high, `rvalid` goes high on the next clock and `rdata` carries the addressed register. Address 1 returns the status bits zero-extended in bits [NUM_PINS-1:0] and clears them.
- R8: An edge detected in the same clock as a status read is not cleared. It appears in the status after the read.
- R9: Status bits stay set until a status read. A pin change applied between clock edges shows at `irq` after the third rising clock edge and not before.
- R10: A write with `cfg_we` high at address 0 loads the mode word. Reading address 0 returns it and leaves the status and `irq` unchanged.
- R11: Counted edges on several pins in the same clock each set their own status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| cfg_we | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 mode word, 1 status |
| wdata | input | 2*NUM_PINS | Write data for the mode word |
| rdata | output | 2*NUM_PINS | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one clock after `rd_en` |
| irq | output | 1 | Port interrupt, high while any status bit is set |

## Verification
A wrong previous-sample flop or a wrong mode decode shows up as a missing or extra status bit. It is visible at `irq` within three clocks of the pin change and on `rdata` at the next status read. A fault in the clear-on-read path appears in one of two ways. Either `irq` stays high after a read, or an edge that arrived during the read goes missing from the read that follows. The bench places an edge in exactly that cycle to expose the second case. A synchronizer with the wrong depth moves the `irq` rise away from the third clock, and the bench samples both before and at that clock.

// File: rtl/piu_pkg.sv
package piu_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   localparam int MODE_BITS = 2;

   localparam logic REG_MODE = 1'b0;
   localparam logic REG_STAT = 1'b1;

endpackage

// File: rtl/piu_sync.sv
module piu_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("piu_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/piu_edge_detect.sv
module piu_edge_detect
   import piu_pkg::*;
#(
   parameter int NUM_PINS = 8,
   localparam int MODE_W  = MODE_BITS * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] level,
   input  logic [MODE_W-1:0]   mode,
   output logic [NUM_PINS-1:0] hit
);

   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      edge_mode_e pin_mode;
      logic       rose;
      logic       fell;

      assign pin_mode = edge_mode_e'(mode[MODE_BITS*i +: MODE_BITS]);
      assign rose     = level[i] & ~prev_q[i];
      assign fell     = ~level[i] & prev_q[i];

      always_comb begin
         unique case (pin_mode)
            EDGE_RISE: hit[i] = rose;
            EDGE_FALL: hit[i] = fell;
            EDGE_BOTH: hit[i] = rose | fell;
            default:   hit[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/piu_status.sv
module piu_status #(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] hit,
   input  logic                clear,
   output logic [NUM_PINS-1:0] status_q
);

   logic [NUM_PINS-1:0] kept;

   assign kept = clear ? '0 : status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= kept | hit;
   end

endmodule

// File: rtl/piu_port_irq.sv
module piu_port_irq
   import piu_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W     = MODE_BITS * NUM_PINS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                cfg_we,
   input  logic                rd_en,
   input  logic                addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                rvalid,
   output logic                irq
);

   if (NUM_PINS < 1 || NUM_PINS > 16) begin : g_bad_pins
      $error("piu_port_irq: NUM_PINS must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("piu_port_irq: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] hit_w;
   logic [NUM_PINS-1:0] status_q;
   logic [DATA_W-1:0]   mode_q;
   logic                stat_read;

   assign stat_read = rd_en && (addr == REG_STAT);

   piu_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   piu_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pin_sync),
      .mode  (mode_q),
      .hit   (hit_w)
   );

   piu_status #(.NUM_PINS(NUM_PINS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_w),
      .clear    (stat_read),
      .status_q (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mode_q <= '0;
      else if (cfg_we && addr == REG_MODE)    mode_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) rdata <= (addr == REG_STAT) ? DATA_W'(status_q) : mode_q;
      end
   end

   assign irq = |status_q;

endmodule

// File: rtl/piu_port_irq_chk.sv
module piu_port_irq_chk #(
   parameter int NUM_PINS = 8,
   localparam int DATA_W  = 2 * NUM_PINS
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_en,
   input logic                addr,
   input logic                rvalid,
   input logic [DATA_W-1:0]   rdata,
   input logic                irq,
   input logic [NUM_PINS-1:0] status_q,
   input logic [NUM_PINS-1:0] hit_w,
   input logic [DATA_W-1:0]   mode_q
);

   logic                stat_rd;
   logic [NUM_PINS-1:0] off_mask;

   assign stat_rd = rd_en && addr;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) off_mask[i] = (mode_q[2*i +: 2] == 2'b00);
   end

   assert_off_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & $past(off_mask)) == '0));

   assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(stat_rd));

   assert_rvalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);

   assert_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (rdata == DATA_W'($past(status_q))));

   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && hit_w != '0) |=> ((status_q & $past(hit_w)) == $past(hit_w)));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

bind piu_port_irq piu_port_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .addr     (addr),
   .rvalid   (rvalid),
   .rdata    (rdata),
   .irq      (irq),
   .status_q (status_q),
   .hit_w    (hit_w),
   .mode_q   (mode_q)
);

// File: tb/test_piu_port_irq.sv
module test_piu_port_irq;

   localparam int NP = 8;
   localparam int DW = 2 * NP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic          cfg_we = 1'b0;
   logic          rd_en = 1'b0;
   logic          addr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   always #4 clk = ~clk;

   piu_port_irq #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_piu_port_irq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data when the design presents a result
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected rvalid", 1, 0);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   // all tasks start and end at a falling clock edge
   task automatic rd(input logic a, input logic [DW-1:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_en = 1'b1;
      addr  = a;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr_mode(input logic [DW-1:0] v);
      cfg_we = 1'b1;
      addr   = 1'b0;
      wdata  = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pins(input logic [NP-1:0] v);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", DW'(irq), 0);
      check("R1 rvalid after reset", DW'(rvalid), 0);
      rd(1'b1, 16'h0000, "R1 status after reset");
      rd(1'b0, 16'h0000, "R1 mode after reset");

      // R2: all pins disabled
      pins(8'hFF);
      check("R2 disabled pins no irq", DW'(irq), 0);
      pins(8'h00);
      rd(1'b1, 16'h0000, "R2 disabled pins no status");

      // modes: pin0 rise, pin1 fall, pin2 any, pin3 off, pin4 rise
      wr_mode(16'h0139);
      rd(1'b0, 16'h0139, "R10 mode readback");

      // R3 and R9 latency
      pin_in = 8'h01;
      repeat (2) @(negedge clk);
      check("R9 irq not before third edge", DW'(irq), 0);
      @(negedge clk);
      check("R9 irq at third edge", DW'(irq), 1);
      repeat (4) @(negedge clk);
      check("R9 status sticky", DW'(irq), 1);
      rd(1'b1, 16'h0001, "R3 rising recorded");
      check("R6 irq low after clearing read", DW'(irq), 0);
      pins(8'h00);
      check("R3 falling ignored in rise mode", DW'(irq), 0);

      // R4
      pins(8'h02);
      check("R4 rising ignored in fall mode", DW'(irq), 0);
      pins(8'h00);
      check("R4 falling sets irq", DW'(irq), 1);
      rd(1'b1, 16'h0002, "R4 falling recorded");

      // R5
      pins(8'h04);
      rd(1'b1, 16'h0004, "R5 any mode rise");
      pins(8'h00);
      rd(1'b1, 16'h0004, "R5 any mode fall");
      pin_in = 8'h04;
      @(negedge clk);
      pins(8'h00);
      rd(1'b1, 16'h0004, "R5 pulse between reads");
      rd(1'b1, 16'h0000, "R7 status cleared by read");

      // R11 with a disabled pin alongside
      pins(8'h19);
      rd(1'b1, 16'h0011, "R11 two pins at once");
      pins(8'h00);
      rd(1'b1, 16'h0000, "R11 falls ignored");

      // R8: edge in the same clock as the read
      pins(8'h01);
      pin_in = 8'h05;
      repeat (2) @(negedge clk);
      rd(1'b1, 16'h0001, "R8 read during edge");
      check("R8 irq kept", DW'(irq), 1);
      rd(1'b1, 16'h0004, "R8 edge not lost");

      pins(8'h00);
      rd(1'b1, 16'h0004, "R5 any fall after R8");

      // R10: mode read does not clear
      pins(8'h01);
      rd(1'b0, 16'h0139, "R10 mode read");
      check("R10 irq unchanged by mode read", DW'(irq), 1);
      rd(1'b1, 16'h0001, "R10 status unchanged");
      check("R6 irq low at end", DW'(irq), 0);

      repeat (2) @(negedge clk);
      check("R7 no pending reads", DW'(exp_q.size()), 0);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule